// File: doc/BRIEF.md
# Paired Byte FIFOs with Programmable Trigger Flags

This block holds two byte queues, one for the outbound direction and one for the inbound direction, each eight entries deep. A single 8-bit control word sets a fill threshold for each queue, the two interrupt enables and a flush bit for each queue. A second register location holds the two threshold flags, which software reads and clears.

The outbound flag rises when the outbound queue has drained to its threshold or below. This tells the producer that there is room to refill. The inbound flag rises when the inbound queue has filled to its threshold or above. This tells the consumer that there is data to collect. Each flag is sticky. Each is gated by its enable to drive an interrupt line.

The queue side is a plain push/pop byte interface. The read data shows the oldest entry before it is popped. A push to a full queue or a pop from an empty queue is dropped and reported by a one-cycle error pulse.

Top module: `duplex_byte_fifo_ctl`

## Requirements
- R1: After reset the control word reads 0, both interrupt outputs are 0 and both queues are empty. The outbound flag reads 1 from the second cycle after reset, and the inbound flag reads 0.
- R2: The CPU port decodes `cpu_addr` 0 as the control word and `cpu_addr` 1 as the flag word. Read bits 31:8 of the control word are always 0, and write values in those bits are ignored. The flag word reads the outbound flag in bit 1 and the inbound flag in bit 0, with all other bits 0.
- R3: Each queue returns bytes in push order, and its pop data shows the oldest entry. Up to 8 bytes are held. A push while 8 are held is dropped, and the matching overflow output is 1 for exactly the one cycle after that push edge.
- R4: A pop from an empty queue changes nothing, and the matching underflow output is 1 for exactly the one cycle after that pop edge.
- R5: Control bits 7:6 give the outbound threshold: 00 means 7, 01 means 6, 10 means 4 and 11 means 2. The outbound flag becomes 1 on the cycle after the outbound count is at or below this threshold.
- R6: Control bits 5:4 give the inbound threshold: 00 means 1, 01 means 2, 10 means 4 and 11 means 6. The inbound flag becomes 1 on the cycle after the inbound count is at or above this threshold.
- R7: A flag stays 1 once set. Writing 0 to its bit at `cpu_addr` 1 clears it, and writing 1 leaves it unchanged. If the threshold condition still holds when the clear is written, the flag stays 1.
- R8: Control bit 3 enables the outbound interrupt. `tx_irq` is 1 exactly when this bit and the outbound flag are both 1, so clearing either one drops it.
- R9: Control bit 2 enables the inbound interrupt. `rx_irq` is 1 exactly when this bit and the inbound flag are both 1, so clearing either one drops it.
- R10: While control bit 1 (outbound) or bit 0 (inbound) is 1, the matching queue is held empty. Pushes to it are dropped without an overflow pulse, and pops give an underflow pulse.
- R11: A push and a pop in the same cycle behave as follows. On a full queue, the pop is taken and the push overflows. On an empty queue, the push is taken and the pop underflows. Otherwise both are taken and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 1 | 0 = control word, 1 = flag word |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational on cpu_addr) |
| tx_push | input | 1 | Push into the outbound queue |
| tx_push_data | input | 8 | Byte to push into the outbound queue |
| tx_pop | input | 1 | Pop from the outbound queue |
| tx_pop_data | output | 8 | Oldest byte in the outbound queue |
| tx_overflow | output | 1 | Outbound dropped-push pulse |
| tx_underflow | output | 1 | Outbound dropped-pop pulse |
| rx_push | input | 1 | Push into the inbound queue |
| rx_push_data | input | 8 | Byte to push into the inbound queue |
| rx_pop | input | 1 | Pop from the inbound queue |
| rx_pop_data | output | 8 | Oldest byte in the inbound queue |
| rx_overflow | output | 1 | Inbound dropped-push pulse |
| rx_underflow | output | 1 | Inbound dropped-pop pulse |
| tx_irq | output | 1 | Outbound interrupt |
| rx_irq | output | 1 | Inbound interrupt |

## Verification
A push and a pop can land on the same queue in the same cycle. The bench drives both strobes in one cycle with the queue full, empty and partly filled. It judges the result from the two error pulses and from draining the queue afterwards to count and order what is left.

A flag clear can also fall in a cycle where the threshold still holds. The bench writes the clear in that state, reads the flag back, and checks that the flag and its interrupt stay up until the count moves past the threshold.

// File: rtl/dbf_pkg.sv
// Package: shared types for the paired byte FIFO block.
// Assumes the control field order below is the bit layout of the control word.
package dbf_pkg;

    // Control word, bits 7..0 from top to bottom.
    typedef struct packed {
        logic [1:0] tx_lvl;   // outbound threshold code
        logic [1:0] rx_lvl;   // inbound threshold code
        logic       tx_ie;    // outbound interrupt enable
        logic       rx_ie;    // inbound interrupt enable
        logic       tx_clr;   // outbound queue flush
        logic       rx_clr;   // inbound queue flush
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dbf_byte_fifo.sv
// Module: byte queue with occupancy count, flush hold and error pulses.
// Assumes DEPTH is a power of two so the pointers wrap by overflow.
module dbf_byte_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          underflow
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          ovf_q, unf_q;
    logic          full, empty, push_ok, pop_ok;

    // Accept decisions, made from the occupancy at the start of the cycle.
    always_comb begin
        full    = (cnt_q == CW'(DEPTH));
        empty   = (cnt_q == '0);
        push_ok = push && !flush && !full;
        pop_ok  = pop && !flush && !empty;
    end

    // Storage write; the array has no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointers and count, all cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
            else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
        end
    end

    // One-cycle error pulses for dropped requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= push && !flush && full;
            unf_q <= pop && (flush || empty);
        end
    end

    assign pop_data  = mem[rd_ptr];
    assign count     = cnt_q;
    assign overflow  = ovf_q;
    assign underflow = unf_q;

    // R3: the count never exceeds the depth.
    p_count_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R3: an overflow pulse follows a push made while full.
    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> $past(push && cnt_q == CW'(DEPTH)));
    // R4: an underflow pulse follows a pop made while empty or flushed.
    p_unf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> $past(pop && (cnt_q == '0 || flush)));
    // R10: a flush leaves the queue empty.
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> cnt_q == '0);

endmodule

// File: rtl/dbf_trig_flag.sv
// Module: sticky threshold flag; IS_TX picks the drain (<=) or fill (>=) test.
// Assumes clr is a one-cycle pulse from the register decode.
module dbf_trig_flag #(
    parameter int unsigned DEPTH = 8,
    parameter bit          IS_TX = 1'b1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    code,
    input  logic [CW-1:0] count,
    input  logic          clr,
    output logic          flag
);

    logic [CW-1:0] thr;
    logic          hit;
    logic          flag_q;

    if (IS_TX) begin : g_drain
        // Drain threshold: the queue has emptied to the level or below.
        always_comb begin
            case (code)
                2'b00:   thr = CW'(DEPTH - 1);
                2'b01:   thr = CW'(DEPTH - 2);
                2'b10:   thr = CW'(DEPTH / 2);
                default: thr = CW'(DEPTH / 4);
            endcase
            hit = (count <= thr);
        end
    end else begin : g_fill
        // Fill threshold: the queue has filled to the level or above.
        always_comb begin
            case (code)
                2'b00:   thr = CW'(1);
                2'b01:   thr = CW'(DEPTH / 4);
                2'b10:   thr = CW'(DEPTH / 2);
                default: thr = CW'(DEPTH - 2);
            endcase
            hit = (count >= thr);
        end
    end

    // Sticky flag: a set by the condition wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q && !clr) || hit;
    end

    assign flag = flag_q;

    // R7: the flag only falls after a clear write.
    p_fall_needs_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr));
    // R5/R6: the flag only rises after the threshold was met.
    p_rise_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(hit));

endmodule

// File: rtl/dbf_ctrl_reg.sv
// Module: control word storage and CPU read/write decode of both registers.
// Assumes a one-bit address: 0 control word, 1 flag word.
module dbf_ctrl_reg
    import dbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_wr,
    input  logic        cpu_addr,
    input  logic [31:0] cpu_wdata,
    input  logic        tx_flag,
    input  logic        rx_flag,
    output ctrl_t       ctrl,
    output logic        tx_flag_clr,
    output logic        rx_flag_clr,
    output logic [31:0] cpu_rdata
);

    ctrl_t ctrl_q;
    logic  unused_hi;

    assign unused_hi = ^cpu_wdata[31:CTRL_W];

    // Control word register; only the low byte is stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctrl_q <= '0;
        else if (cpu_wr && !cpu_addr)  ctrl_q <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);
    end

    // Flag clear strobes: writing 0 to a flag bit clears it.
    always_comb begin
        tx_flag_clr = cpu_wr && cpu_addr && !cpu_wdata[1];
        rx_flag_clr = cpu_wr && cpu_addr && !cpu_wdata[0];
    end

    // Read mux with zero-filled upper bits.
    always_comb begin
        if (cpu_addr) cpu_rdata = {30'd0, tx_flag, rx_flag};
        else          cpu_rdata = {{(32 - CTRL_W){1'b0}}, ctrl_q};
    end

    assign ctrl = ctrl_q;

    // R2: reserved bits of the control word read as zero.
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr |-> cpu_rdata[31:CTRL_W] == '0);

endmodule

// File: rtl/duplex_byte_fifo_ctl.sv
// Module: top level; two byte queues, two threshold flags and interrupt gating.
// Assumes the queue depth is a power of two and at least 8.
module duplex_byte_fifo_ctl
    import dbf_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_wr,
    input  logic          cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_push_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    output logic          tx_overflow,
    output logic          tx_underflow,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_pop_data,
    output logic          rx_overflow,
    output logic          rx_underflow,
    output logic          tx_irq,
    output logic          rx_irq
);

    ctrl_t         ctrl;
    logic          tx_flag, rx_flag, tx_flag_clr, rx_flag_clr;
    logic [CW-1:0] tx_cnt, rx_cnt;

    dbf_ctrl_reg i_regs (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .tx_flag(tx_flag), .rx_flag(rx_flag),
        .ctrl(ctrl), .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr),
        .cpu_rdata(cpu_rdata)
    );

    dbf_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_tx_q (
        .clk(clk), .rst_n(rst_n), .flush(ctrl.tx_clr),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .pop_data(tx_pop_data), .count(tx_cnt),
        .overflow(tx_overflow), .underflow(tx_underflow)
    );

    dbf_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rx_q (
        .clk(clk), .rst_n(rst_n), .flush(ctrl.rx_clr),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .pop_data(rx_pop_data), .count(rx_cnt),
        .overflow(rx_overflow), .underflow(rx_underflow)
    );

    dbf_trig_flag #(.DEPTH(DEPTH), .IS_TX(1'b1)) i_tx_flag (
        .clk(clk), .rst_n(rst_n), .code(ctrl.tx_lvl), .count(tx_cnt),
        .clr(tx_flag_clr), .flag(tx_flag)
    );

    dbf_trig_flag #(.DEPTH(DEPTH), .IS_TX(1'b0)) i_rx_flag (
        .clk(clk), .rst_n(rst_n), .code(ctrl.rx_lvl), .count(rx_cnt),
        .clr(rx_flag_clr), .flag(rx_flag)
    );

    // Interrupt gating: each line is its flag masked by its enable.
    always_comb begin
        tx_irq = tx_flag && ctrl.tx_ie;
        rx_irq = rx_flag && ctrl.rx_ie;
    end

    // R8: dropping the outbound enable silences the outbound line.
    p_tx_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.tx_ie) |-> !tx_irq);
    // R9: dropping the inbound enable silences the inbound line.
    p_rx_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.rx_ie) |-> !rx_irq);

endmodule

// File: tb/test_duplex_byte_fifo_ctl.sv
`timescale 1ns/1ps
module test_duplex_byte_fifo_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_addr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]  tx_push_data = '0, rx_push_data = '0;
    logic [7:0]  tx_pop_data, rx_pop_data;
    logic        tx_overflow, tx_underflow, rx_overflow, rx_underflow;
    logic        tx_irq, rx_irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    duplex_byte_fifo_ctl i_duplex_byte_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .tx_overflow(tx_overflow), .tx_underflow(tx_underflow),
        .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop),
        .rx_pop_data(rx_pop_data), .rx_overflow(rx_overflow), .rx_underflow(rx_underflow),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // Vector: {code[1:0], fill[3:0], exp_tx_flag, exp_rx_flag}; code drives both thresholds.
    localparam int NV = 13;
    localparam logic [7:0] VEC [NV] = '{
        {2'd0, 4'd7, 1'b1, 1'b1}, {2'd0, 4'd8, 1'b0, 1'b1}, {2'd0, 4'd0, 1'b1, 1'b0},
        {2'd1, 4'd6, 1'b1, 1'b1}, {2'd1, 4'd7, 1'b0, 1'b1}, {2'd1, 4'd1, 1'b1, 1'b0},
        {2'd2, 4'd4, 1'b1, 1'b1}, {2'd2, 4'd5, 1'b0, 1'b1}, {2'd2, 4'd3, 1'b1, 1'b0},
        {2'd3, 4'd2, 1'b1, 1'b0}, {2'd3, 4'd3, 1'b0, 1'b0}, {2'd3, 4'd6, 1'b0, 1'b1},
        {2'd3, 4'd8, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic a, input logic [31:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); #1;
        cpu_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [31:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    // One cycle on the outbound queue; rd is the head before the edge.
    task automatic tx_op(input logic p, input logic [7:0] d, input logic q,
                         output logic [7:0] rd, output logic ovf, output logic unf);
        @(negedge clk);
        rd = tx_pop_data;
        tx_push = p; tx_push_data = d; tx_pop = q;
        @(posedge clk); #1;
        ovf = tx_overflow; unf = tx_underflow;
        tx_push = 1'b0; tx_pop = 1'b0;
    endtask

    task automatic rx_op(input logic p, input logic [7:0] d, input logic q,
                         output logic [7:0] rd, output logic ovf, output logic unf);
        @(negedge clk);
        rd = rx_pop_data;
        rx_push = p; rx_push_data = d; rx_pop = q;
        @(posedge clk); #1;
        ovf = rx_overflow; unf = rx_underflow;
        rx_push = 1'b0; rx_pop = 1'b0;
    endtask

    // Flush both queues and load the control word.
    task automatic setup(input logic [7:0] c);
        wr_reg(1'b0, {24'd0, c[7:2], 2'b11});
        wr_reg(1'b0, {24'd0, c[7:2], 2'b00});
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  rd;
        logic        ov, un;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state.
        rd_reg(1'b0, r); chk("R1 ctrl after reset", r, 32'h0);
        rd_reg(1'b1, r); chk("R1 flags after reset", r, 32'h2);
        chk("R1 irq after reset", {tx_irq, rx_irq}, 2'b00);
        tx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R1 tx empty after reset", un, 1'b1);

        // R2: reserved bits ignored on write, zero on read.
        wr_reg(1'b0, 32'hFFFF_FF30);
        rd_reg(1'b0, r); chk("R2 reserved bits", r, 32'h0000_0030);
        wr_reg(1'b0, 32'h0);

        // R5/R6: threshold table.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] code;
            int         fill;
            code = VEC[i][7:6];
            fill = int'(VEC[i][5:2]);
            setup({code, code, 4'b0000});
            for (int k = 0; k < fill; k++) begin
                tx_op(1'b1, 8'(k), 1'b0, rd, ov, un);
                rx_op(1'b1, 8'(k), 1'b0, rd, ov, un);
            end
            idle(2);
            wr_reg(1'b1, 32'h0);
            idle(2);
            rd_reg(1'b1, r);
            chk($sformatf("R5 tx flag code %0d fill %0d", code, fill), r[1], VEC[i][1]);
            chk($sformatf("R6 rx flag code %0d fill %0d", code, fill), r[0], VEC[i][0]);
        end

        // R3/R4: order, overflow at 9th push, underflow after drain.
        setup(8'h00);
        for (int k = 0; k < 8; k++) tx_op(1'b1, 8'hA0 + 8'(k), 1'b0, rd, ov, un);
        tx_op(1'b1, 8'h55, 1'b0, rd, ov, un); chk("R3 overflow pulse", ov, 1'b1);
        idle(1); chk("R3 overflow one cycle", tx_overflow, 1'b0);
        for (int k = 0; k < 8; k++) begin
            tx_op(1'b0, 8'h0, 1'b1, rd, ov, un);
            chk($sformatf("R3 order %0d", k), rd, 8'hA0 + 8'(k));
        end
        tx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R4 underflow pulse", un, 1'b1);
        idle(1); chk("R4 underflow one cycle", tx_underflow, 1'b0);

        // R7: sticky flag; clear refused while condition holds.
        idle(2);
        wr_reg(1'b1, 32'h0);
        rd_reg(1'b1, r); chk("R7 clear refused while held", r[1], 1'b1);
        for (int k = 0; k < 8; k++) tx_op(1'b1, 8'(k), 1'b0, rd, ov, un);
        idle(2);
        rd_reg(1'b1, r); chk("R7 flag sticky", r[1], 1'b1);
        wr_reg(1'b1, 32'h1);
        rd_reg(1'b1, r); chk("R7 clear taken", r[1], 1'b0);

        // R8: outbound interrupt gating (queue full, flag clear, level 7).
        wr_reg(1'b0, 32'h08);
        chk("R8 irq low with flag clear", tx_irq, 1'b0);
        tx_op(1'b0, 8'h0, 1'b1, rd, ov, un);
        idle(2); chk("R8 irq on at level", tx_irq, 1'b1);
        wr_reg(1'b0, 32'h00); chk("R8 irq off by enable", tx_irq, 1'b0);
        wr_reg(1'b0, 32'h08); chk("R8 irq back with enable", tx_irq, 1'b1);
        tx_op(1'b1, 8'h0, 1'b0, rd, ov, un);
        idle(2);
        wr_reg(1'b1, 32'h1); chk("R8 irq off by flag clear", tx_irq, 1'b0);

        // R9: inbound interrupt gating, level 2.
        setup(8'h14);
        wr_reg(1'b1, 32'h0);
        rx_op(1'b1, 8'h11, 1'b0, rd, ov, un);
        idle(2); chk("R9 irq below level", rx_irq, 1'b0);
        rx_op(1'b1, 8'h22, 1'b0, rd, ov, un);
        idle(2); chk("R9 irq at level", rx_irq, 1'b1);
        wr_reg(1'b0, 32'h10); chk("R9 irq off by enable", rx_irq, 1'b0);
        wr_reg(1'b0, 32'h14); chk("R9 irq back with enable", rx_irq, 1'b1);
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un);
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un);
        idle(2);
        wr_reg(1'b1, 32'h2); chk("R9 irq off by flag clear", rx_irq, 1'b0);

        // R10: flush held; pushes dropped silently.
        wr_reg(1'b0, 32'h02);
        tx_op(1'b1, 8'h77, 1'b0, rd, ov, un); chk("R10 no overflow while held", ov, 1'b0);
        tx_op(1'b1, 8'h78, 1'b0, rd, ov, un);
        tx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R10 pop underflows while held", un, 1'b1);
        wr_reg(1'b0, 32'h00);
        tx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R10 empty after release", un, 1'b1);

        // R11: push and pop together on full, empty and partial queues.
        setup(8'h00);
        for (int k = 0; k < 8; k++) rx_op(1'b1, 8'h30 + 8'(k), 1'b0, rd, ov, un);
        rx_op(1'b1, 8'hEE, 1'b1, rd, ov, un);
        chk("R11 full: push overflows", ov, 1'b1);
        chk("R11 full: pop taken", {un, rd}, {1'b0, 8'h30});
        for (int k = 1; k < 8; k++) begin
            rx_op(1'b0, 8'h0, 1'b1, rd, ov, un);
            chk($sformatf("R11 full drain %0d", k), rd, 8'h30 + 8'(k));
        end
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R11 full left 7", un, 1'b1);
        rx_op(1'b1, 8'h5A, 1'b1, rd, ov, un);
        chk("R11 empty: pop underflows, push taken", {ov, un}, 2'b01);
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R11 empty: pushed byte", rd, 8'h5A);
        rx_op(1'b1, 8'h61, 1'b0, rd, ov, un);
        rx_op(1'b1, 8'h62, 1'b0, rd, ov, un);
        rx_op(1'b1, 8'h63, 1'b1, rd, ov, un);
        chk("R11 partial: no pulses", {ov, un, rd}, {2'b00, 8'h61});
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R11 partial head", rd, 8'h62);
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R11 partial tail", rd, 8'h63);
        rx_op(1'b0, 8'h0, 1'b1, rd, ov, un); chk("R11 partial count kept", un, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule